// File: doc/BRIEF.md
# Descending Memory Stack Controller

This block runs a last-in first-out stack inside a fixed window of an external word-addressed memory. A stack pointer register marks the current top. The stack grows toward lower addresses: its empty value sits one word above the window, and the window ends at a lower bound. A push first moves the pointer down one word and then writes the data register at the new top. A pop first reads the word at the top into the data register and then moves the pointer up one word. Each accepted operation takes exactly two clock cycles, and `busy` is high for both.

The memory has a single address bus. Three address registers share it: a program counter, a data address register and the stack pointer. While the block is idle, a two-bit select input chooses which of them drives the bus. While a stack operation is running, the stack pointer drives the bus. The program counter and the data address register are plain loadable registers here. The memory is assumed to return read data one cycle after it sees an address.

A push on a full stack is refused and raises an overflow pulse. A pop on an empty stack is refused and raises an underflow pulse. In both cases the pointer and the memory stay as they were.

Top module: `mstk_ctrl`

## Requirements
- R1: After reset the stack pointer equals SP_INIT (default 4001), `dr_q` is zero, and `busy`, `ovf`, `unf` and `mem_we` are low.
- R2: The stack pointer always stays between SP_LOW (default 3000) and SP_INIT, both included, and it moves by at most one per cycle.
- R3: An accepted push keeps `busy` high for two cycles. At the end of the first cycle the pointer drops by one. In the second cycle `mem_we` is high, `mem_addr` is the new pointer and `mem_wdata` is `dr_q`.
- R4: An accepted pop keeps `busy` high for two cycles, with `mem_we` low and `mem_addr` equal to the pointer in both cycles. At the end of the second cycle `dr_q` takes `mem_rdata` and the pointer rises by one.
- R5: A push request while the pointer equals SP_LOW is refused. In the next cycle `ovf` is high for that one cycle, `busy` stays low, and neither the pointer nor the memory changes.
- R6: A pop request while the pointer equals SP_INIT is refused. In the next cycle `unf` is high for that one cycle, `busy` stays low, and the pointer does not change.
- R7: While idle, `mem_addr` follows `addr_sel`: 0 selects the program counter, 1 the data address register, 2 the stack pointer, and 3 the program counter (or the stack pointer when ALT_SP is 1). While `busy` is high the stack pointer drives `mem_addr`, whatever `addr_sel` is.
- R8: `pc_ld` and `ar_ld` load `pc_din` and `ar_din` into their registers at the clock edge.
- R9: While `busy` is high, push requests, pop requests and `dr_ld` have no effect.
- R10: When a push request and a pop request arrive together while idle, only the push is acted on.
- R11: Items come back from pops in the reverse order of their pushes. The first item pushed goes to SP_INIT-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| push_req | input | 1 | Request a push of the data register |
| pop_req | input | 1 | Request a pop into the data register |
| dr_ld | input | 1 | Load `dr_din` into the data register when idle |
| dr_din | input | DW | Data register load value |
| pc_ld | input | 1 | Load the program counter |
| pc_din | input | AW | Program counter load value |
| ar_ld | input | 1 | Load the data address register |
| ar_din | input | AW | Data address register load value |
| addr_sel | input | 2 | Address source select used while idle |
| mem_addr | output | AW | Shared memory address bus |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, valid one cycle after the address |
| dr_q | output | DW | Data register contents |
| sp_q | output | AW | Stack pointer contents |
| busy | output | 1 | A stack operation is in progress |
| ovf | output | 1 | One-cycle pulse for a refused push |
| unf | output | 1 | One-cycle pulse for a refused pop |

## Verification
A wrong stack pointer shows up at `mem_addr` in the second cycle of the next push, as a write to the wrong word. It also shows up on `sp_q` right after the step that corrupted it. A pointer that is off by one word in either direction makes the next pop return a neighbouring item, so the reverse-order readback catches it within two cycles of the faulty pop. A wrong bound test is caught by the sweep that fills the window to its lower limit and then drains it. That sweep shows the error as a missing or spurious flag pulse in the cycle right after the request.

// File: rtl/mstk_pkg.sv
package mstk_pkg;

   typedef enum logic [1:0] {
      SRC_PC  = 2'd0,
      SRC_AR  = 2'd1,
      SRC_SP  = 2'd2,
      SRC_ALT = 2'd3
   } addr_src_e;

   typedef enum logic [2:0] {
      ST_IDLE     = 3'd0,
      ST_PUSH_DEC = 3'd1,
      ST_PUSH_WR  = 3'd2,
      ST_POP_RD   = 3'd3,
      ST_POP_INC  = 3'd4
   } seq_state_e;

endpackage

// File: rtl/mstk_areg.sv
module mstk_areg #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         ld,
   input  logic [W-1:0] din,
   output logic [W-1:0] q
);
   always_ff @(posedge clk) begin
      if (!rst_n)  q <= '0;
      else if (ld) q <= din;
   end
endmodule

// File: rtl/mstk_sp.sv
module mstk_sp #(
   parameter int AW      = 16,
   parameter int SP_INIT = 4001,
   parameter int SP_LOW  = 3000
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          dec,
   input  logic          inc,
   output logic [AW-1:0] sp_q,
   output logic          at_low,
   output logic          at_top
);
   localparam logic [AW-1:0] TOP_V = AW'(SP_INIT);
   localparam logic [AW-1:0] LOW_V = AW'(SP_LOW);

   always_ff @(posedge clk) begin
      if (!rst_n)   sp_q <= TOP_V;
      else if (dec) sp_q <= sp_q - 1'b1;
      else if (inc) sp_q <= sp_q + 1'b1;
   end

   assign at_low = (sp_q == LOW_V);
   assign at_top = (sp_q == TOP_V);

   // R2: pointer inside its window
   p_sp_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (sp_q >= LOW_V) && (sp_q <= TOP_V));

   // R2: pointer moves by one word at most
   p_sp_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (sp_q != $past(sp_q)) |->
         ((sp_q == $past(sp_q) + 1'b1) || (sp_q == $past(sp_q) - 1'b1)));
endmodule

// File: rtl/mstk_seq.sv
module mstk_seq
   import mstk_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       push_req,
   input  logic       pop_req,
   input  logic       at_low,
   input  logic       at_top,
   output seq_state_e state_q,
   output logic       sp_dec,
   output logic       sp_inc,
   output logic       dr_cap,
   output logic       wr_en,
   output logic       ovf_q,
   output logic       unf_q
);
   seq_state_e state_d;
   logic       ovf_d, unf_d;

   always_comb begin
      state_d = state_q;
      ovf_d   = 1'b0;
      unf_d   = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (push_req) begin
               if (at_low) ovf_d   = 1'b1;
               else        state_d = ST_PUSH_DEC;
            end else if (pop_req) begin
               if (at_top) unf_d   = 1'b1;
               else        state_d = ST_POP_RD;
            end
         end
         ST_PUSH_DEC: state_d = ST_PUSH_WR;
         ST_PUSH_WR:  state_d = ST_IDLE;
         ST_POP_RD:   state_d = ST_POP_INC;
         ST_POP_INC:  state_d = ST_IDLE;
         default:     state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         ovf_q   <= 1'b0;
         unf_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         ovf_q   <= ovf_d;
         unf_q   <= unf_d;
      end
   end

   assign sp_dec = (state_q == ST_PUSH_DEC);
   assign sp_inc = (state_q == ST_POP_INC);
   assign dr_cap = (state_q == ST_POP_INC);
   assign wr_en  = (state_q == ST_PUSH_WR);

   // R5/R6: never both flags at once
   p_flags_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(ovf_q && unf_q));
endmodule

// File: rtl/mstk_amux.sv
module mstk_amux
   import mstk_pkg::*;
#(
   parameter int AW     = 16,
   parameter bit ALT_SP = 1'b0
) (
   input  logic [AW-1:0] pc,
   input  logic [AW-1:0] ar,
   input  logic [AW-1:0] sp,
   input  logic [1:0]    sel,
   input  logic          stack_own,
   output logic [AW-1:0] addr
);
   logic [AW-1:0] alt_src;

   generate
      if (ALT_SP) begin : g_alt_sp
         assign alt_src = sp;
      end else begin : g_alt_pc
         assign alt_src = pc;
      end
   endgenerate

   always_comb begin
      if (stack_own) addr = sp;
      else begin
         unique case (addr_src_e'(sel))
            SRC_PC:  addr = pc;
            SRC_AR:  addr = ar;
            SRC_SP:  addr = sp;
            default: addr = alt_src;
         endcase
      end
   end
endmodule

// File: rtl/mstk_ctrl.sv
module mstk_ctrl
   import mstk_pkg::*;
#(
   parameter int AW      = 16,
   parameter int DW      = 16,
   parameter int SP_INIT = 4001,
   parameter int SP_LOW  = 3000,
   parameter bit ALT_SP  = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push_req,
   input  logic          pop_req,
   input  logic          dr_ld,
   input  logic [DW-1:0] dr_din,
   input  logic          pc_ld,
   input  logic [AW-1:0] pc_din,
   input  logic          ar_ld,
   input  logic [AW-1:0] ar_din,
   input  logic [1:0]    addr_sel,
   output logic [AW-1:0] mem_addr,
   output logic          mem_we,
   output logic [DW-1:0] mem_wdata,
   input  logic [DW-1:0] mem_rdata,
   output logic [DW-1:0] dr_q,
   output logic [AW-1:0] sp_q,
   output logic          busy,
   output logic          ovf,
   output logic          unf
);
   localparam int NAREG = 2;
   localparam int DEPTH = SP_INIT - SP_LOW;

   initial begin : elab_chk
      assert (SP_LOW < SP_INIT) else $error("stack window empty");
      assert (SP_INIT < (1 << AW)) else $error("SP_INIT exceeds address width");
      assert (DEPTH >= 1) else $error("stack depth must be positive");
      assert (DW >= 1) else $error("data width must be positive");
   end

   seq_state_e    state;
   logic          sp_dec, sp_inc, dr_cap, wr_en, at_low, at_top;
   logic          ld_v   [NAREG];
   logic [AW-1:0] din_v  [NAREG];
   logic [AW-1:0] areg_q [NAREG];

   assign ld_v[0]  = pc_ld;
   assign din_v[0] = pc_din;
   assign ld_v[1]  = ar_ld;
   assign din_v[1] = ar_din;

   generate
      for (genvar g = 0; g < NAREG; g++) begin : g_areg
         mstk_areg #(.W(AW)) u_reg (
            .clk(clk), .rst_n(rst_n), .ld(ld_v[g]), .din(din_v[g]), .q(areg_q[g])
         );
      end
   endgenerate

   mstk_seq u_seq (
      .clk(clk), .rst_n(rst_n), .push_req(push_req), .pop_req(pop_req),
      .at_low(at_low), .at_top(at_top), .state_q(state),
      .sp_dec(sp_dec), .sp_inc(sp_inc), .dr_cap(dr_cap), .wr_en(wr_en),
      .ovf_q(ovf), .unf_q(unf)
   );

   mstk_sp #(.AW(AW), .SP_INIT(SP_INIT), .SP_LOW(SP_LOW)) u_sp (
      .clk(clk), .rst_n(rst_n), .dec(sp_dec), .inc(sp_inc),
      .sp_q(sp_q), .at_low(at_low), .at_top(at_top)
   );

   assign busy = (state != ST_IDLE);

   mstk_amux #(.AW(AW), .ALT_SP(ALT_SP)) u_amux (
      .pc(areg_q[0]), .ar(areg_q[1]), .sp(sp_q), .sel(addr_sel),
      .stack_own(busy), .addr(mem_addr)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)                dr_q <= '0;
      else if (dr_cap)           dr_q <= mem_rdata;
      else if (dr_ld && !busy)   dr_q <= dr_din;
   end

   assign mem_we    = wr_en;
   assign mem_wdata = dr_q;

   // R3: every write lands at the stack pointer
   p_wr_at_sp_r3: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> (mem_addr == sp_q));

   // R9: writes only inside a stack operation
   p_we_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> busy);

   // R5: refused push leaves a full, unmoved pointer
   p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ovf |-> ($stable(sp_q) && at_low && !busy));

   // R6: refused pop leaves an empty, unmoved pointer
   p_no_underflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
      unf |-> ($stable(sp_q) && at_top && !busy));
endmodule

// File: tb/mstk_ctrl_test.sv
`timescale 1ns/1ps
module mstk_ctrl_test;
   localparam int AW = 8, DW = 8, TOP = 20, LOW = 12, N = TOP - LOW;

   logic clk = 1'b0, rst_n = 1'b0;
   logic push_req = 0, pop_req = 0, dr_ld = 0, pc_ld = 0, ar_ld = 0;
   logic [DW-1:0] dr_din = '0, mem_rdata;
   logic [AW-1:0] pc_din = '0, ar_din = '0, mem_addr, sp_q;
   logic [1:0] addr_sel = 2'd0;
   logic mem_we, busy, ovf, unf;
   logic [DW-1:0] mem_wdata, dr_q;
   logic [DW-1:0] bmem [256];
   int total = 0, bad = 0, exp_sp = TOP;

   always #2.5 clk = ~clk;

   mstk_ctrl #(.AW(AW), .DW(DW), .SP_INIT(TOP), .SP_LOW(LOW)) uut (
      .clk(clk), .rst_n(rst_n), .push_req(push_req), .pop_req(pop_req),
      .dr_ld(dr_ld), .dr_din(dr_din), .pc_ld(pc_ld), .pc_din(pc_din),
      .ar_ld(ar_ld), .ar_din(ar_din), .addr_sel(addr_sel),
      .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .dr_q(dr_q), .sp_q(sp_q), .busy(busy),
      .ovf(ovf), .unf(unf)
   );

   always @(posedge clk) begin
      if (mem_we) bmem[mem_addr] <= mem_wdata;
      mem_rdata <= bmem[mem_addr];
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int item(input int i);
      return (i * 37 + 5) & 8'hFF;
   endfunction

   task automatic do_push(input int v, input bit poke);
      @(negedge clk); dr_ld = 1; dr_din = DW'(v);
      @(negedge clk); dr_ld = 0; push_req = 1;
      @(negedge clk); push_req = 0;
      chk(busy && !mem_we, "R3 first cycle", int'(busy), 1);
      if (poke) begin pop_req = 1; push_req = 1; dr_ld = 1; dr_din = 8'hEE; end
      @(negedge clk); pop_req = 0; push_req = 0; dr_ld = 0;
      chk(busy && mem_we, "R3 write cycle", int'(mem_we), 1);
      chk(mem_addr == AW'(exp_sp - 1), "R3/R7 write address", int'(mem_addr), exp_sp - 1);
      chk(mem_wdata == DW'(v), "R3 write data", int'(mem_wdata), v);
      @(negedge clk);
      exp_sp--;
      chk(!busy && sp_q == AW'(exp_sp), "R3 pointer after push", int'(sp_q), exp_sp);
      if (poke) chk(dr_q == DW'(v), "R9 dr load ignored", int'(dr_q), v);
   endtask

   task automatic do_pop(input int v);
      @(negedge clk); pop_req = 1;
      @(negedge clk); pop_req = 0;
      chk(busy && !mem_we && mem_addr == AW'(exp_sp), "R4 read cycle", int'(mem_addr), exp_sp);
      @(negedge clk);
      chk(busy && !mem_we && mem_addr == AW'(exp_sp), "R4 second cycle", int'(mem_addr), exp_sp);
      @(negedge clk);
      exp_sp++;
      chk(!busy && sp_q == AW'(exp_sp), "R4 pointer after pop", int'(sp_q), exp_sp);
      chk(dr_q == DW'(v), "R11 popped value", int'(dr_q), v);
   endtask

   initial begin : watchdog
      #(5.0 * 100000);
      bad++; total++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk(sp_q == AW'(TOP), "R1 pointer", int'(sp_q), TOP);
      chk(!busy && !ovf && !unf && !mem_we, "R1 controls", int'(busy), 0);
      chk(dr_q == '0, "R1 data reg", int'(dr_q), 0);

      pc_ld = 1; pc_din = 8'h55; ar_ld = 1; ar_din = 8'hA3;
      @(negedge clk); pc_ld = 0; ar_ld = 0;
      for (int s = 0; s < 4; s++) begin
         int e;
         addr_sel = 2'(s);
         e = (s == 1) ? 8'hA3 : (s == 2) ? TOP : 8'h55;
         #1;
         chk(mem_addr == AW'(e), "R7/R8 address select", int'(mem_addr), e);
      end
      addr_sel = 2'd0;

      @(negedge clk); pop_req = 1;
      @(negedge clk); pop_req = 0;
      chk(unf && !busy && sp_q == AW'(TOP), "R6 underflow pulse", int'(unf), 1);
      @(negedge clk);
      chk(!unf && sp_q == AW'(TOP), "R6 pulse ends", int'(unf), 0);

      for (int i = 0; i < N; i++) do_push(item(i), i == 0);

      @(negedge clk); dr_ld = 1; dr_din = 8'h77;
      @(negedge clk); dr_ld = 0; push_req = 1;
      @(negedge clk); push_req = 0;
      chk(ovf && !busy && !mem_we, "R5 overflow pulse", int'(ovf), 1);
      chk(sp_q == AW'(LOW), "R5 pointer held", int'(sp_q), LOW);
      @(negedge clk);
      chk(!ovf, "R5 pulse ends", int'(ovf), 0);

      for (int i = N - 1; i >= 0; i--) do_pop(item(i));

      @(negedge clk); push_req = 1; pop_req = 1; dr_ld = 1; dr_din = 8'h3C;
      @(negedge clk); push_req = 0; pop_req = 0; dr_ld = 0;
      @(negedge clk);
      chk(mem_we && mem_addr == AW'(TOP - 1), "R10 push wins", int'(mem_we), 1);
      @(negedge clk);
      exp_sp = TOP - 1;
      chk(sp_q == AW'(exp_sp), "R10 pointer", int'(sp_q), exp_sp);
      do_pop(8'h3C);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule